// File: doc/BRIEF.md
# Cascaded Mappable Interrupt Controller

This block gathers device interrupt requests and presents them to a processor on two interrupt lines. It has two local groups of eight request bits. Each local group has a status register and a mask register, and each group drives one processor interrupt output. A third group of eight mappable requests shares a single status register. Two independent mask registers filter that status. Each filtered result is reduced to one bit, and that bit appears at a fixed position inside one of the local groups. A mapped device can therefore reach either processor line, or both, depending only on the mask contents.

Most status bits capture a rising edge of their request and hold it until software clears it. Software clears a bit by writing a 1 to that bit of the status register. One local source, the FIFO-full bit at position 0 of local group 0, is not held at all: its status bit follows the live input. Two timer-tick inputs set two pending latches. Software clears them through a dedicated timer-clear register, one bit per timer. The register bus carries a 3-bit word index, single-cycle write and read strobes, and 32-bit data. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, all four mask registers, every held status bit and both timer pending bits are zero, and `cpu_irq` is 2'b00.
- R2: A rising edge on a held request (local 0 bits 1..6, local 1 bits 0..2 and 4..7, and all mapped bits) sets its status bit. The bit stays set after the request falls. Writing 1 to that bit of its status register clears it, and writing 0 leaves it unchanged.
- R3: `cpu_irq[n]` is high exactly when (local group n status AND local group n mask) is nonzero.
- R4: Local group 0 status bit 0 equals the present level of `loc0_req[0]` with no clock delay, and writing 1 to it has no effect.
- R5: Local group 0 status bit 7 is the OR of (mapped status AND map mask 0). Local group 1 status bit 3 is the OR of (mapped status AND map mask 1). The raw inputs `loc0_req[7]` and `loc1_req[3]` are ignored, and writing 1 to these two cascade bits in a local status register has no effect.
- R6: The four mask registers (index 1 local 0 mask, 3 local 1 mask, 5 map mask 0, 6 map mask 1) store `bus_wdata[7:0]` when written and read back what was stored.
- R7: A rising edge on `tmr_tick[t]` sets timer pending bit t. The pending bits read as bits 1:0 at index 7. Writing 1 to bit t at index 7 clears pending bit t.
- R8: Register indices are 0 local 0 status, 1 local 0 mask, 2 local 1 status, 3 local 1 mask, 4 mapped status, 5 map mask 0, 6 map mask 1, 7 timer clear/pending. Bits above each register's width read as zero, and `bus_rdata` is zero whenever `bus_rd` is low.
- R9: When a rising request edge and a clearing write hit the same held bit in the same cycle, the bit is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned combinationally |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| loc0_req | input | 8 | Local group 0 requests (bit 0 live, bit 7 ignored) |
| loc1_req | input | 8 | Local group 1 requests (bit 3 ignored) |
| map_req | input | 8 | Mappable requests |
| tmr_tick | input | 2 | Timer tick inputs |
| cpu_irq | output | 2 | Processor interrupt lines, one per local group |

## Verification
The bench builds the block with its default parameters: eight-bit groups, two timers, cascade bits at positions 7 and 3, and the live bit at position 0. At that size every case can be tried in turn. All 256 values of each mask register are written and read back. Every held bit position of every group is set and cleared individually. For nine mapped-status patterns, all 256 mask values are swept through both cascade paths, with the expected cascade bit and processor line computed arithmetically. The same-cycle edge-versus-clear collision is also exercised on both a mapped bit and a timer bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_AW = 3;
    localparam int REG_N  = 1 << REG_AW;

    // Word indices of the register bank
    typedef enum logic [REG_AW-1:0] {
        REG_L0_STAT   = 3'd0,
        REG_L0_MASK   = 3'd1,
        REG_L1_STAT   = 3'd2,
        REG_L1_MASK   = 3'd3,
        REG_MAP_STAT  = 3'd4,
        REG_MAP_MASK0 = 3'd5,
        REG_MAP_MASK1 = 3'd6,
        REG_TMR_CLR   = 3'd7
    } irqc_reg_e;

    // Slots inside the mask bank
    localparam int MSK_L0   = 0;
    localparam int MSK_L1   = 1;
    localparam int MSK_MAP0 = 2;
    localparam int MSK_MAP1 = 3;
    localparam int MSK_N    = 4;

endpackage

// File: rtl/irqc_edge_latch.sv
// Bank of edge-captured, write-one-to-clear pending bits.
// A new edge in the same cycle as a clear leaves the bit set.
module irqc_edge_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);

    logic [W-1:0] req_q;
    logic [W-1:0] stat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[i]  <= 1'b0;
                stat_q[i] <= 1'b0;
            end else begin
                req_q[i]  <= req[i];
                stat_q[i] <= (stat_q[i] & ~clr[i]) | (req[i] & ~req_q[i]);
            end
        end
    end

    assign stat = stat_q;

endmodule

// File: rtl/irqc_mask_bank.sv
// Set of independently written mask registers.
module irqc_mask_bank #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr_en,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] masks
);

    for (genvar k = 0; k < N; k++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                masks[k] <= '0;
            end else if (wr_en[k]) begin
                masks[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter int GRP_W     = 8,
    parameter int TMR_N     = 2,
    parameter int DATA_W    = 32,
    parameter int CASC0_POS = 7,
    parameter int CASC1_POS = 3,
    parameter int LIVE_POS  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [GRP_W-1:0]  loc0_req,
    input  logic [GRP_W-1:0]  loc1_req,
    input  logic [GRP_W-1:0]  map_req,
    input  logic [TMR_N-1:0]  tmr_tick,
    output logic [1:0]        cpu_irq
);

    localparam logic [GRP_W-1:0] ONE_BIT  = {{(GRP_W-1){1'b0}}, 1'b1};
    localparam logic [GRP_W-1:0] C0_BIT   = ONE_BIT << CASC0_POS;
    localparam logic [GRP_W-1:0] C1_BIT   = ONE_BIT << CASC1_POS;
    localparam logic [GRP_W-1:0] LV_BIT   = ONE_BIT << LIVE_POS;
    localparam logic [GRP_W-1:0] L0_HELD  = ~(C0_BIT | LV_BIT);
    localparam logic [GRP_W-1:0] L1_HELD  = ~C1_BIT;

    // ---------------- write decode ----------------
    logic [REG_N-1:0]  wr_sel;
    logic [GRP_W-1:0]  wd_lo;
    logic              unused_wdata_hi;

    assign wr_sel          = bus_wr ? (REG_N'(1) << bus_addr) : '0;
    assign wd_lo           = bus_wdata[GRP_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:GRP_W];

    logic [GRP_W-1:0] l0_clr, l1_clr, map_clr;
    logic [TMR_N-1:0] tmr_clr;

    assign l0_clr  = wr_sel[REG_L0_STAT]  ? (wd_lo & L0_HELD) : '0;
    assign l1_clr  = wr_sel[REG_L1_STAT]  ? (wd_lo & L1_HELD) : '0;
    assign map_clr = wr_sel[REG_MAP_STAT] ? wd_lo : '0;
    assign tmr_clr = wr_sel[REG_TMR_CLR]  ? bus_wdata[TMR_N-1:0] : '0;

    // ---------------- mask registers ----------------
    logic [MSK_N-1:0]            mask_we;
    logic [MSK_N-1:0][GRP_W-1:0] masks;
    logic [GRP_W-1:0]            l0_mask, l1_mask, mmask0, mmask1;

    assign mask_we[MSK_L0]   = wr_sel[REG_L0_MASK];
    assign mask_we[MSK_L1]   = wr_sel[REG_L1_MASK];
    assign mask_we[MSK_MAP0] = wr_sel[REG_MAP_MASK0];
    assign mask_we[MSK_MAP1] = wr_sel[REG_MAP_MASK1];

    irqc_mask_bank #(
        .W (GRP_W),
        .N (MSK_N)
    ) u_masks (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_we),
        .wdata (wd_lo),
        .masks (masks)
    );

    assign l0_mask = masks[MSK_L0];
    assign l1_mask = masks[MSK_L1];
    assign mmask0  = masks[MSK_MAP0];
    assign mmask1  = masks[MSK_MAP1];

    // ---------------- pending latches ----------------
    logic [GRP_W-1:0] l0_held, l1_held, map_stat;
    logic [TMR_N-1:0] tmr_pend;

    irqc_edge_latch #(.W(GRP_W)) u_l0_lat (
        .clk (clk), .rst_n (rst_n),
        .req (loc0_req & L0_HELD), .clr (l0_clr), .stat (l0_held)
    );

    irqc_edge_latch #(.W(GRP_W)) u_l1_lat (
        .clk (clk), .rst_n (rst_n),
        .req (loc1_req & L1_HELD), .clr (l1_clr), .stat (l1_held)
    );

    irqc_edge_latch #(.W(GRP_W)) u_map_lat (
        .clk (clk), .rst_n (rst_n),
        .req (map_req), .clr (map_clr), .stat (map_stat)
    );

    irqc_edge_latch #(.W(TMR_N)) u_tmr_lat (
        .clk (clk), .rst_n (rst_n),
        .req (tmr_tick), .clr (tmr_clr), .stat (tmr_pend)
    );

    // ---------------- cascade and group status ----------------
    logic             casc0, casc1;
    logic [GRP_W-1:0] l0_stat, l1_stat;

    assign casc0   = |(map_stat & mmask0);
    assign casc1   = |(map_stat & mmask1);
    assign l0_stat = (l0_held & L0_HELD) | (loc0_req & LV_BIT) | (casc0 ? C0_BIT : '0);
    assign l1_stat = (l1_held & L1_HELD) | (casc1 ? C1_BIT : '0);

    assign cpu_irq[0] = |(l0_stat & l0_mask);
    assign cpu_irq[1] = |(l1_stat & l1_mask);

    // ---------------- read path ----------------
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        unique case (irqc_reg_e'(bus_addr))
            REG_L0_STAT:   rd_word[GRP_W-1:0] = l0_stat;
            REG_L0_MASK:   rd_word[GRP_W-1:0] = l0_mask;
            REG_L1_STAT:   rd_word[GRP_W-1:0] = l1_stat;
            REG_L1_MASK:   rd_word[GRP_W-1:0] = l1_mask;
            REG_MAP_STAT:  rd_word[GRP_W-1:0] = map_stat;
            REG_MAP_MASK0: rd_word[GRP_W-1:0] = mmask0;
            REG_MAP_MASK1: rd_word[GRP_W-1:0] = mmask1;
            REG_TMR_CLR:   rd_word[TMR_N-1:0] = tmr_pend;
            default:       rd_word = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_word : '0;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int GRP_W  = 8,
    parameter int TMR_N  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [GRP_W-1:0]  map_req,
    input logic [TMR_N-1:0]  tmr_tick,
    input logic [1:0]        cpu_irq,
    input logic [GRP_W-1:0]  l0_mask,
    input logic [GRP_W-1:0]  l1_mask,
    input logic [GRP_W-1:0]  mmask0,
    input logic [GRP_W-1:0]  map_stat,
    input logic [TMR_N-1:0]  tmr_pend
);

    logic [GRP_W-1:0] map_req_d;
    logic [GRP_W-1:0] map_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_req_d <= '0;
        else        map_req_d <= map_req;
    end
    assign map_rise = map_req & ~map_req_d;

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (l0_mask == '0 && l1_mask == '0 && map_stat == '0
                          && tmr_pend == '0 && cpu_irq == 2'b00))
        else $error("R1 state not clean after reset");

    assert_map_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_MAP_STAT) |=> ((map_stat & $past(map_stat)) == $past(map_stat)))
        else $error("R2 mapped bit dropped without a clear");

    assert_l0_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_mask == '0) |-> !cpu_irq[0])
        else $error("R3 line 0 high with empty mask");

    assert_l1_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_mask == '0) |-> !cpu_irq[1])
        else $error("R3 line 1 high with empty mask");

    assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_MAP_MASK0) |=> (mmask0 == $past(bus_wdata[GRP_W-1:0])))
        else $error("R6 map mask 0 not stored");

    for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
        assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == REG_TMR_CLR && bus_wdata[t] && !tmr_tick[t]) |=> !tmr_pend[t])
            else $error("R7 timer bit not cleared");
    end

    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0))
        else $error("R8 read data not zero while idle");

    assert_mask_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_L0_MASK) |-> (bus_rdata[DATA_W-1:GRP_W] == '0))
        else $error("R8 undefined bits nonzero");

    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (map_rise != '0) |=> ((map_stat & $past(map_rise)) == $past(map_rise)))
        else $error("R9 new edge lost");

endmodule

bind irq_cascade_ctrl irqc_checker #(
    .GRP_W  (GRP_W),
    .TMR_N  (TMR_N),
    .DATA_W (DATA_W)
) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .map_req   (map_req),
    .tmr_tick  (tmr_tick),
    .cpu_irq   (cpu_irq),
    .l0_mask   (l0_mask),
    .l1_mask   (l1_mask),
    .mmask0    (mmask0),
    .map_stat  (map_stat),
    .tmr_pend  (tmr_pend)
);

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
    import irqc_pkg::*;

    localparam int CLK_P  = 10;
    localparam int GRP_W  = 8;
    localparam int TMR_N  = 2;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [GRP_W-1:0]  loc0_req = '0;
    logic [GRP_W-1:0]  loc1_req = '0;
    logic [GRP_W-1:0]  map_req = '0;
    logic [TMR_N-1:0]  tmr_tick = '0;
    logic [1:0]        cpu_irq;

    irq_cascade_ctrl #(
        .GRP_W (GRP_W), .TMR_N (TMR_N), .DATA_W (DATA_W)
    ) u_irq_cascade_ctrl (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .loc0_req (loc0_req), .loc1_req (loc1_req), .map_req (map_req),
        .tmr_tick (tmr_tick), .cpu_irq (cpu_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input irqc_reg_e r, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = r; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input irqc_reg_e r, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = r;
        #1;
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic [1:0] exp);
        @(negedge clk);
        #1;
        check(tag, {30'b0, cpu_irq}, {30'b0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: reset contents of every register
        irq_chk("R1 cpu_irq after reset", 2'b00);
        for (int r = 0; r < REG_N; r++)
            rd_chk("R1 register zero after reset", irqc_reg_e'(r), 32'h0);

        // R8: idle read data
        @(negedge clk); #1;
        check("R8 rdata idle", bus_rdata, 32'h0);

        // R6 / R8: every value in every mask register, upper write bits ignored
        for (int m = 0; m < 4; m++) begin
            irqc_reg_e mr;
            mr = (m == 0) ? REG_L0_MASK : (m == 1) ? REG_L1_MASK :
                 (m == 2) ? REG_MAP_MASK0 : REG_MAP_MASK1;
            for (int v = 0; v < 256; v++) begin
                wr(mr, {24'hA5C3F0, 8'(v)});
                rd_chk("R6 mask readback", mr, {24'h0, 8'(v)});
            end
            wr(mr, 32'h0);
        end

        // R2 / R3: held bits of local group 0
        for (int b = 1; b < 7; b++) begin
            logic [7:0] bv;
            bv = 8'h01 << b;
            wr(REG_L0_MASK, {24'h0, bv});
            @(negedge clk); loc0_req = bv;
            @(negedge clk); loc0_req = '0;
            rd_chk("R2 local0 bit set", REG_L0_STAT, {24'h0, bv});
            irq_chk("R3 line 0 raised", 2'b01);
            wr(REG_L0_STAT, {24'h0, ~bv});
            rd_chk("R2 local0 zero write keeps bit", REG_L0_STAT, {24'h0, bv});
            wr(REG_L0_MASK, 32'h0);
            irq_chk("R3 line 0 masked", 2'b00);
            wr(REG_L0_STAT, {24'h0, bv});
            rd_chk("R2 local0 bit cleared", REG_L0_STAT, 32'h0);
        end

        // R2 / R3: held bits of local group 1
        for (int b = 0; b < 8; b++) begin
            logic [7:0] bv;
            if (b == 3) continue;
            bv = 8'h01 << b;
            wr(REG_L1_MASK, {24'h0, bv});
            @(negedge clk); loc1_req = bv;
            @(negedge clk); loc1_req = '0;
            rd_chk("R2 local1 bit set", REG_L1_STAT, {24'h0, bv});
            irq_chk("R3 line 1 raised", 2'b10);
            wr(REG_L1_STAT, {24'h0, bv});
            rd_chk("R2 local1 bit cleared", REG_L1_STAT, 32'h0);
            irq_chk("R3 line 1 dropped", 2'b00);
        end
        wr(REG_L1_MASK, 32'h0);

        // R2: mapped bits
        for (int b = 0; b < 8; b++) begin
            logic [7:0] bv;
            bv = 8'h01 << b;
            @(negedge clk); map_req = bv;
            @(negedge clk); map_req = '0;
            rd_chk("R2 mapped bit set", REG_MAP_STAT, {24'h0, bv});
            wr(REG_MAP_STAT, {24'h0, bv});
            rd_chk("R2 mapped bit cleared", REG_MAP_STAT, 32'h0);
        end

        // R4: live FIFO-full bit
        wr(REG_L0_MASK, 32'h01);
        @(negedge clk); loc0_req = 8'h01; #1;
        check("R4 live bit drives line 0 at once", {30'b0, cpu_irq}, 32'h1);
        rd_chk("R4 live bit visible", REG_L0_STAT, 32'h01);
        wr(REG_L0_STAT, 32'h01);
        rd_chk("R4 clear write ignored", REG_L0_STAT, 32'h01);
        @(negedge clk); loc0_req = '0; #1;
        check("R4 live bit follows level", {30'b0, cpu_irq}, 32'h0);
        rd_chk("R4 live bit low", REG_L0_STAT, 32'h0);

        // R5: raw inputs at cascade positions ignored
        wr(REG_L0_MASK, 32'h80);
        wr(REG_L1_MASK, 32'h08);
        @(negedge clk); loc0_req = 8'h80; loc1_req = 8'h08;
        @(negedge clk); loc0_req = '0;    loc1_req = '0;
        rd_chk("R5 loc0 bit7 input ignored", REG_L0_STAT, 32'h0);
        rd_chk("R5 loc1 bit3 input ignored", REG_L1_STAT, 32'h0);
        irq_chk("R5 no line from ignored inputs", 2'b00);

        // R5 / R3: cascade sweep over mapped patterns and all mask values
        for (int pi = 0; pi < 9; pi++) begin
            logic [7:0] p;
            p = (pi < 8) ? (8'h01 << pi) : 8'hA5;
            @(negedge clk); map_req = p;
            @(negedge clk); map_req = '0;
            for (int m = 0; m < 256; m++) begin
                logic c0, c1;
                c0 = ((p & 8'(m)) != 8'h0);
                c1 = ((p & ~8'(m)) != 8'h0);
                wr(REG_MAP_MASK0, {24'h0, 8'(m)});
                wr(REG_MAP_MASK1, {24'h0, ~8'(m)});
                rd_chk("R5 cascade into local0 bit 7", REG_L0_STAT, c0 ? 32'h80 : 32'h0);
                rd_chk("R5 cascade into local1 bit 3", REG_L1_STAT, c1 ? 32'h08 : 32'h0);
                irq_chk("R3 lines from cascade", {c1, c0});
            end
            wr(REG_MAP_STAT, 32'hFF);
        end

        // R5: cascade bit not cleared by a local write, cleared at its source
        @(negedge clk); map_req = 8'h10;
        @(negedge clk); map_req = '0;
        wr(REG_MAP_MASK0, 32'h10);
        wr(REG_L0_STAT, 32'h80);
        rd_chk("R5 local write leaves cascade bit", REG_L0_STAT, 32'h80);
        wr(REG_MAP_STAT, 32'h10);
        rd_chk("R5 cascade bit follows mapped clear", REG_L0_STAT, 32'h0);
        irq_chk("R5 line 0 dropped", 2'b00);
        wr(REG_MAP_MASK0, 32'h0);
        wr(REG_MAP_MASK1, 32'h0);

        // R7: timer pending and clear
        @(negedge clk); tmr_tick = 2'b01;
        @(negedge clk); tmr_tick = 2'b00;
        rd_chk("R7 timer 0 pending", REG_TMR_CLR, 32'h1);
        @(negedge clk); tmr_tick = 2'b10;
        @(negedge clk); tmr_tick = 2'b00;
        rd_chk("R7 both timers pending", REG_TMR_CLR, 32'h3);
        wr(REG_TMR_CLR, 32'h1);
        rd_chk("R7 timer 0 cleared alone", REG_TMR_CLR, 32'h2);
        wr(REG_TMR_CLR, 32'h2);
        rd_chk("R7 timer 1 cleared", REG_TMR_CLR, 32'h0);

        // R9: edge and clear in the same cycle
        @(negedge clk);
        map_req = 8'h20; bus_wr = 1'b1; bus_addr = REG_MAP_STAT; bus_wdata = 32'h20;
        @(negedge clk);
        map_req = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R9 mapped edge beats clear", REG_MAP_STAT, 32'h20);
        wr(REG_MAP_STAT, 32'h20);
        rd_chk("R9 later clear succeeds", REG_MAP_STAT, 32'h0);
        @(negedge clk);
        tmr_tick = 2'b10; bus_wr = 1'b1; bus_addr = REG_TMR_CLR; bus_wdata = 32'h3;
        @(negedge clk);
        tmr_tick = 2'b00; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R9 timer edge beats clear", REG_TMR_CLR, 32'h2);

        // R8: idle read with state present
        @(negedge clk); bus_addr = REG_TMR_CLR; #1;
        check("R8 rdata zero without read strobe", bus_rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule